// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block takes a DDR3 channel from power-on to a usable state once a start pulse arrives. It holds the memory reset, releases it, raises the clock enable and waits for the power-up windows. The length of each window is given in nanoseconds and turned into clock cycles from the clock-period parameter. It then writes the four mode registers of each populated chip select and ends with two long ZQ calibration commands. Every command leaves the block as a one-cycle strobe with a chip-select index, a bank code and an address word, ready for the command path of a memory controller.

The mode-register values are built from two termination inputs: a 3-bit nominal on-die termination code and a 2-bit dynamic write termination code. The other mode-register fields are fixed. The select mask, the registered-module flag and both termination codes are captured when a start is accepted. Changing them during a run has no effect.

Top module: `ddr3_pwrup_seq`

## Requirements
- R1: After reset, `mem_rst_no`, `cke_o`, `cmd_vld_o` and `done_o` are all low. When a start is accepted, `mem_rst_no` stays low for ceil(T_RST_NS/period) cycles and then goes high.
- R2: `cke_o` rises ceil(T_CKE_NS/period) cycles after `mem_rst_no` rises. The first command strobe comes ceil(T_XPR_NS/period) cycles after that. No strobe is issued while `cke_o` is low.
- R3: Each selected chip select gets four mode-register writes in this order: bank 2, bank 3, bank 1, bank 0. `cs_o` carries the select index and `cmd_zq_o` is low for all four.
- R4: The bank-0 write carries address 0x0528: bit 8 resets the DLL, bit 3 selects interleaved burst, bits 6:4 hold 2 and bits 11:9 hold 2. The next strobe follows ceil(T_DLL_NS/period) idle cycles later.
- R5: The bank-1 write has address bit 1 set. Termination code bit 0 goes to address bit 2, code bit 1 to address bit 6 and code bit 2 to address bit 9. All other bits are zero.
- R6: The bank-2 write has address bit 6 set and the dynamic termination code in bits 10:9. The bank-3 write has an all-zero address.
- R7: Selects whose mask bit is clear are skipped. Without the registered-module flag only the lowest populated select is written. With the flag every populated select is written, in ascending order.
- R8: After the mode-register phase come two ZQ strobes, each with `cmd_zq_o`=1, bank 0 and address 0x0400. The first goes to the even select of the lowest populated pair and the second to the odd one. With an all-zero mask, select 0 and then select 1 are used and no mode-register write is issued. `done_o` rises the cycle after the second ZQ strobe.
- R9: Every strobe lasts one cycle. Strobes other than the one after the bank-0 write are separated by exactly MR_GAP idle cycles. When no strobe is issued, `cs_o`, `ba_o` and `addr_o` are zero.
- R10: A start while a sequence runs is ignored. A start while `done_o` is high begins a new sequence with reset asserted and `cke_o` low.
- R11: The mask, the registered-module flag and both termination codes are sampled when a start is accepted. Later changes do not alter the running sequence.
- R12: Asserting `rst_ni` at any time immediately returns the block to idle, with reset asserted and `cke_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request pulse |
| cs_present_i | input | NUM_CS | Populated chip-select mask |
| rdimm_i | input | 1 | Registered modules present |
| rtt_nom_i | input | 3 | Nominal termination code |
| rtt_wr_i | input | 2 | Dynamic write termination code |
| mem_rst_no | output | 1 | Memory reset, active low |
| cke_o | output | 1 | Clock enable |
| cmd_vld_o | output | 1 | Command strobe |
| cmd_zq_o | output | 1 | Strobe is a ZQ long calibration (else mode-register write) |
| cs_o | output | CS_W | Target chip select |
| ba_o | output | 3 | Bank code |
| addr_o | output | ADDR_W | Address word |
| done_o | output | 1 | Sequence complete |

## Verification
Two events can fall in the same cycle: a start request, and either a strobe, the end of a wait window or the final ZQ strobe. The bench pulses start in the middle of the reset window and again in the middle of the mode-register phase. It also pulses start in the very cycle after `done_o` rises and asserts `rst_ni` during a wait window. A behavioural queue model, built from the requirements when a start is accepted, says per cycle whether the start is dropped, restarts the run or is pre-empted by reset. Every output is compared with the model on every clock.

// File: rtl/ddr3_pwrup_pkg.sv
package ddr3_pwrup_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RST, ST_CKE, ST_XPR, ST_CMD, ST_GAP, ST_DONE
  } seq_state_e;

  // order of issue within one chip select, then calibration
  typedef enum logic [2:0] {
    STEP_MR2, STEP_MR3, STEP_MR1, STEP_MR0, STEP_ZQ0, STEP_ZQ1
  } seq_step_e;

  function automatic longint ns_to_cyc(longint ns, longint period_ps);
    longint c;
    c = (ns * 64'sd1000 + period_ps - 64'sd1) / period_ps;
    if (c < 64'sd1) c = 64'sd1;
    return c;
  endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i - W'(1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/cs_scan.sv
module cs_scan #(
  parameter int NUM_CS = 4,
  parameter int CS_W   = 2
) (
  input  logic [NUM_CS-1:0] mask_i,
  input  logic [CS_W:0]     from_i,
  output logic              found_o,
  output logic [CS_W-1:0]   idx_o
);
  // lowest populated select at or above from_i
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (mask_i[i] && ((CS_W+1)'(i) >= from_i)) begin
        found_o = 1'b1;
        idx_o   = CS_W'(i);
      end
    end
  end
endmodule

// File: rtl/mr_encoder.sv
module mr_encoder
  import ddr3_pwrup_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  seq_step_e         step_i,
  input  logic [2:0]        rtt_nom_i,
  input  logic [1:0]        rtt_wr_i,
  output logic [2:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              zq_o
);
  always_comb begin
    ba_o   = 3'd0;
    addr_o = '0;
    zq_o   = 1'b0;
    case (step_i)
      STEP_MR2: begin
        ba_o        = 3'd2;
        addr_o[6]   = 1'b1;
        addr_o[10:9] = rtt_wr_i;
      end
      STEP_MR3: ba_o = 3'd3;
      STEP_MR1: begin
        ba_o      = 3'd1;
        addr_o[1] = 1'b1;
        addr_o[2] = rtt_nom_i[0];
        addr_o[6] = rtt_nom_i[1];
        addr_o[9] = rtt_nom_i[2];
      end
      STEP_MR0: begin
        addr_o[3]    = 1'b1;
        addr_o[6:4]  = 3'd2;
        addr_o[8]    = 1'b1;
        addr_o[11:9] = 3'd2;
      end
      default: begin
        zq_o       = 1'b1;
        addr_o[10] = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/ddr3_pwrup_seq.sv
module ddr3_pwrup_seq
  import ddr3_pwrup_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 4000,
  parameter int T_RST_NS      = 200000,
  parameter int T_CKE_NS      = 500000,
  parameter int T_XPR_NS      = 360,
  parameter int T_DLL_NS      = 500000,
  parameter int MR_GAP        = 4,
  parameter int NUM_CS        = 4,
  parameter int ADDR_W        = 16,
  parameter int CS_W          = $clog2(NUM_CS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [NUM_CS-1:0] cs_present_i,
  input  logic              rdimm_i,
  input  logic [2:0]        rtt_nom_i,
  input  logic [1:0]        rtt_wr_i,
  output logic              mem_rst_no,
  output logic              cke_o,
  output logic              cmd_vld_o,
  output logic              cmd_zq_o,
  output logic [CS_W-1:0]   cs_o,
  output logic [2:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);
  localparam longint N_RST = ns_to_cyc(T_RST_NS, CLK_PERIOD_PS);
  localparam longint N_CKE = ns_to_cyc(T_CKE_NS, CLK_PERIOD_PS);
  localparam longint N_XPR = ns_to_cyc(T_XPR_NS, CLK_PERIOD_PS);
  localparam longint N_GAP = (MR_GAP < 1) ? 64'sd1 : longint'(MR_GAP);
  localparam longint N_DL0 = ns_to_cyc(T_DLL_NS, CLK_PERIOD_PS);
  localparam longint N_DLL = (N_DL0 > N_GAP) ? N_DL0 : N_GAP;
  localparam longint N_M1  = (N_RST > N_CKE) ? N_RST : N_CKE;
  localparam longint N_M2  = (N_XPR > N_DLL) ? N_XPR : N_DLL;
  localparam longint N_MAX = (N_M1 > N_M2) ? N_M1 : N_M2;
  localparam int     TMR_W = $clog2(N_MAX + 1) + 1;

  seq_state_e state_q;
  seq_step_e  step_q;
  logic [CS_W-1:0]   cs_q, zq_base_q;
  logic [NUM_CS-1:0] mask_q;
  logic              rdimm_q;
  logic [2:0]        nom_q;
  logic [1:0]        wr_q;

  logic              tmr_load, tmr_zero;
  logic [TMR_W-1:0]  tmr_val;
  logic              first_found, next_found, enc_zq;
  logic [CS_W-1:0]   first_idx, next_idx;
  logic [2:0]        enc_ba;
  logic [ADDR_W-1:0] enc_addr;

  cs_scan #(.NUM_CS(NUM_CS), .CS_W(CS_W)) i_first (
    .mask_i (cs_present_i),
    .from_i ('0),
    .found_o(first_found),
    .idx_o  (first_idx)
  );

  cs_scan #(.NUM_CS(NUM_CS), .CS_W(CS_W)) i_next (
    .mask_i (mask_q),
    .from_i ({1'b0, cs_q} + (CS_W+1)'(1)),
    .found_o(next_found),
    .idx_o  (next_idx)
  );

  mr_encoder #(.ADDR_W(ADDR_W)) i_enc (
    .step_i   (step_q),
    .rtt_nom_i(nom_q),
    .rtt_wr_i (wr_q),
    .ba_o     (enc_ba),
    .addr_o   (enc_addr),
    .zq_o     (enc_zq)
  );

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = TMR_W'(N_GAP);
    case (state_q)
      ST_IDLE, ST_DONE: begin tmr_load = start_i;  tmr_val = TMR_W'(N_RST); end
      ST_RST:           begin tmr_load = tmr_zero; tmr_val = TMR_W'(N_CKE); end
      ST_CKE:           begin tmr_load = tmr_zero; tmr_val = TMR_W'(N_XPR); end
      ST_CMD: begin
        tmr_load = (step_q != STEP_ZQ1);
        tmr_val  = (step_q == STEP_MR0) ? TMR_W'(N_DLL) : TMR_W'(N_GAP);
      end
      default: ;
    endcase
  end

  seq_timer #(.W(TMR_W)) i_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(tmr_load),
    .val_i (tmr_val),
    .zero_o(tmr_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      step_q    <= STEP_MR2;
      cs_q      <= '0;
      zq_base_q <= '0;
      mask_q    <= '0;
      rdimm_q   <= 1'b0;
      nom_q     <= '0;
      wr_q      <= '0;
    end else begin
      case (state_q)
        ST_IDLE, ST_DONE: if (start_i) begin
          state_q   <= ST_RST;
          mask_q    <= cs_present_i;
          rdimm_q   <= rdimm_i;
          nom_q     <= rtt_nom_i;
          wr_q      <= rtt_wr_i;
          cs_q      <= first_found ? first_idx : '0;
          zq_base_q <= first_found ? (first_idx & ~CS_W'(1)) : '0;
          step_q    <= first_found ? STEP_MR2 : STEP_ZQ0;
        end
        ST_RST: if (tmr_zero) state_q <= ST_CKE;
        ST_CKE: if (tmr_zero) state_q <= ST_XPR;
        ST_XPR: if (tmr_zero) state_q <= ST_CMD;
        ST_GAP: if (tmr_zero) state_q <= ST_CMD;
        ST_CMD: begin
          state_q <= (step_q == STEP_ZQ1) ? ST_DONE : ST_GAP;
          case (step_q)
            STEP_MR2: step_q <= STEP_MR3;
            STEP_MR3: step_q <= STEP_MR1;
            STEP_MR1: step_q <= STEP_MR0;
            STEP_MR0: begin
              if (rdimm_q && next_found) begin
                step_q <= STEP_MR2;
                cs_q   <= next_idx;
              end else begin
                step_q <= STEP_ZQ0;
                cs_q   <= zq_base_q;
              end
            end
            STEP_ZQ0: begin
              step_q <= STEP_ZQ1;
              cs_q   <= cs_q | CS_W'(1);
            end
            default: ;
          endcase
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_rst_no = !(state_q inside {ST_IDLE, ST_RST});
  assign cke_o      = state_q inside {ST_XPR, ST_CMD, ST_GAP, ST_DONE};
  assign cmd_vld_o  = (state_q == ST_CMD);
  assign cmd_zq_o   = cmd_vld_o && enc_zq;
  assign cs_o       = cmd_vld_o ? cs_q : '0;
  assign ba_o       = cmd_vld_o ? enc_ba : '0;
  assign addr_o     = cmd_vld_o ? enc_addr : '0;
  assign done_o     = (state_q == ST_DONE);

endmodule

// File: rtl/ddr3_pwrup_seq_chk.sv
module ddr3_pwrup_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int CS_W   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_rst_no,
  input logic              cke_o,
  input logic              cmd_vld_o,
  input logic              cmd_zq_o,
  input logic [CS_W-1:0]   cs_o,
  input logic [2:0]        ba_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              done_o
);
  p_single_strobe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_o |=> !cmd_vld_o);

  p_cmd_needs_cke_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_o |-> (cke_o && mem_rst_no));

  p_cke_after_rst_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_o |-> mem_rst_no);

  p_done_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!cmd_vld_o && cke_o));

  p_done_after_zq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(cmd_vld_o && cmd_zq_o && cs_o[0]));

  p_mr0_value_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_vld_o && !cmd_zq_o && ba_o == 3'd0) |-> (addr_o == ADDR_W'(16'h0528)));

  p_mr3_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_vld_o && !cmd_zq_o && ba_o == 3'd3) |-> (addr_o == '0));

  p_idle_outputs_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_vld_o |-> (ba_o == 3'd0 && addr_o == '0 && cs_o == '0 && !cmd_zq_o));
endmodule

bind ddr3_pwrup_seq ddr3_pwrup_seq_chk #(.ADDR_W(ADDR_W), .CS_W(CS_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mem_rst_no(mem_rst_no),
  .cke_o     (cke_o),
  .cmd_vld_o (cmd_vld_o),
  .cmd_zq_o  (cmd_zq_o),
  .cs_o      (cs_o),
  .ba_o      (ba_o),
  .addr_o    (addr_o),
  .done_o    (done_o)
);

// File: tb/test_ddr3_pwrup_seq.sv
`timescale 1ns/1ps
module test_ddr3_pwrup_seq;
  // 4 ns period: 100 ns ->25, 160 ns ->40, 360 ns ->90, 120 ns ->30 cycles
  localparam int NR = 25, NC = 40, NX = 90, ND = 30, NG = 3;

  typedef struct packed {
    logic        rst_n;
    logic        cke;
    logic        vld;
    logic        zq;
    logic [1:0]  cs;
    logic [2:0]  ba;
    logic [15:0] addr;
    logic        done;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [3:0] cs_present_i = '0;
  logic rdimm_i = 1'b0;
  logic [2:0] rtt_nom_i = '0;
  logic [1:0] rtt_wr_i = '0;
  logic mem_rst_no, cke_o, cmd_vld_o, cmd_zq_o, done_o;
  logic [1:0] cs_o;
  logic [2:0] ba_o;
  logic [15:0] addr_o;

  int errors = 0, checks = 0;
  exp_t q[$];
  exp_t exp_v = '0;
  string tag = "R1";

  always #2 clk = ~clk;

  ddr3_pwrup_seq #(
    .CLK_PERIOD_PS(4000), .T_RST_NS(100), .T_CKE_NS(160), .T_XPR_NS(360),
    .T_DLL_NS(120), .MR_GAP(NG), .NUM_CS(4), .ADDR_W(16)
  ) i_ddr3_pwrup_seq (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .cs_present_i(cs_present_i),
    .rdimm_i(rdimm_i), .rtt_nom_i(rtt_nom_i), .rtt_wr_i(rtt_wr_i),
    .mem_rst_no(mem_rst_no), .cke_o(cke_o), .cmd_vld_o(cmd_vld_o), .cmd_zq_o(cmd_zq_o),
    .cs_o(cs_o), .ba_o(ba_o), .addr_o(addr_o), .done_o(done_o)
  );

  task automatic push_n(exp_t e, int n);
    for (int i = 0; i < n; i++) q.push_back(e);
  endtask

  task automatic push_cmd(int c, int ba, logic [15:0] addr, logic zq, int gap);
    exp_t e = '0;
    e.rst_n = 1'b1; e.cke = 1'b1;
    push_n(e, 0);
    e.vld = 1'b1; e.zq = zq; e.cs = 2'(c); e.ba = 3'(ba); e.addr = addr;
    q.push_back(e);
    e = '0; e.rst_n = 1'b1; e.cke = 1'b1;
    push_n(e, gap);
  endtask

  task automatic build(logic [3:0] mask, logic rd, logic [2:0] nom, logic [1:0] wr);
    exp_t e = '0;
    int first = -1;
    logic [15:0] mr1, mr2;
    int base;
    mr1 = 16'h0002 | (16'(nom[0]) << 2) | (16'(nom[1]) << 6) | (16'(nom[2]) << 9);
    mr2 = 16'h0040 | (16'(wr) << 9);
    push_n(e, NR);
    e.rst_n = 1'b1; push_n(e, NC);
    e.cke = 1'b1;   push_n(e, NX);
    for (int c = 0; c < 4; c++) begin
      if (mask[c]) begin
        if (first >= 0 && !rd) break;
        if (first < 0) first = c;
        push_cmd(c, 2, mr2, 1'b0, NG);
        push_cmd(c, 3, 16'h0000, 1'b0, NG);
        push_cmd(c, 1, mr1, 1'b0, NG);
        push_cmd(c, 0, 16'h0528, 1'b0, ND);
      end
    end
    base = (first < 0) ? 0 : (first & ~1);
    push_cmd(base, 0, 16'h0400, 1'b1, NG);
    push_cmd(base + 1, 0, 16'h0400, 1'b1, 0);
    e = '0; e.rst_n = 1'b1; e.cke = 1'b1; e.done = 1'b1;
    q.push_back(e);
  endtask

  task automatic field(string f, string rq, logic [15:0] got, logic [15:0] want, inout bit bad);
    if (got !== want) begin
      $display("FAIL %s [%s] %s got=%h exp=%h t=%0t", rq, tag, f, got, want, $time);
      bad = 1'b1;
    end
  endtask

  task automatic compare();
    bit bad = 1'b0;
    checks++;
    field("mem_rst_n", "R1", 16'(mem_rst_no), 16'(exp_v.rst_n), bad);
    field("cke", "R2", 16'(cke_o), 16'(exp_v.cke), bad);
    field("cmd_vld", "R9", 16'(cmd_vld_o), 16'(exp_v.vld), bad);
    field("cmd_zq", "R8", 16'(cmd_zq_o), 16'(exp_v.zq), bad);
    field("cs", "R7", 16'(cs_o), 16'(exp_v.cs), bad);
    field("ba", "R3", 16'(ba_o), 16'(exp_v.ba), bad);
    field("addr", "R5", addr_o, exp_v.addr, bad);
    field("done", "R8", 16'(done_o), 16'(exp_v.done), bad);
    if (bad) errors++;
  endtask

  // model advance for the coming edge, then compare away from it
  task automatic tick();
    if (!rst_ni) begin
      q.delete(); exp_v = '0;
    end else if (q.size() > 0) begin
      exp_v = q.pop_front();
    end else if (start_i) begin
      build(cs_present_i, rdimm_i, rtt_nom_i, rtt_wr_i);
      exp_v = q.pop_front();
    end
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic pulse_start();
    start_i = 1'b1; tick(); start_i = 1'b0;
  endtask

  task automatic run_until_done();
    int k = 0;
    tick();
    while (!exp_v.done && k < 3000) begin tick(); k++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R1 watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    tag = "R1 reset state";
    repeat (3) tick();
    rst_ni = 1'b1;
    repeat (3) tick();

    tag = "R3 R4 R5 R6 R7 R9 unbuffered single select";
    cs_present_i = 4'b0110; rdimm_i = 1'b0; rtt_nom_i = 3'b101; rtt_wr_i = 2'b10;
    pulse_start();
    run_until_done();
    repeat (4) tick();

    tag = "R7 R10 R11 registered selects";
    cs_present_i = 4'b1011; rdimm_i = 1'b1; rtt_nom_i = 3'b010; rtt_wr_i = 2'b01;
    pulse_start();
    repeat (5) tick();
    pulse_start();
    cs_present_i = 4'b0001; rdimm_i = 1'b0; rtt_nom_i = 3'b111; rtt_wr_i = 2'b11;
    repeat (170) tick();
    pulse_start();
    run_until_done();

    tag = "R8 empty mask";
    cs_present_i = 4'b0000; rdimm_i = 1'b1;
    pulse_start();
    run_until_done();

    tag = "R10 R2 restart from done";
    cs_present_i = 4'b1100; rdimm_i = 1'b1; rtt_nom_i = 3'b011; rtt_wr_i = 2'b11;
    pulse_start();
    run_until_done();

    tag = "R12 async reset";
    cs_present_i = 4'b0001; rdimm_i = 1'b0; rtt_nom_i = 3'b100; rtt_wr_i = 2'b00;
    pulse_start();
    repeat (60) tick();
    rst_ni = 1'b0;
    q.delete(); exp_v = '0;
    #1 compare();
    repeat (2) tick();
    rst_ni = 1'b1;
    tick();
    tag = "R1 R2 after reset";
    pulse_start();
    run_until_done();
    repeat (3) tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule